// File: doc/BRIEF.md
# Receive frame filter

This block sits in the receive path of a gigabit Ethernet MAC, between the byte stream that leaves the framing logic and the receive buffer. It reads the destination address and EtherType at the head of every frame and issues one forward-or-drop verdict per frame. The verdict depends on the frame's class (unicast, multicast, broadcast or MAC-control pause), on a set of per-class enable flags, and on two programmed 48-bit addresses. The frame bytes themselves pass through untouched with a fixed two-cycle delay. Because of that delay, the verdict lands on the output byte that carries the last header byte.

A separate strobe reports a received pause request to the flow-control logic, together with its 16-bit pause time. The downstream buffer uses the verdict to commit or discard the frame it is writing. The flow-control logic uses the strobe to hold off transmission.

Top module: `rx_frame_filter`

## Requirements
- R1: `fw_data`, `fw_valid`, `fw_sof` and `fw_eof` repeat `rx_data`, `rx_valid`, `rx_sof` and `rx_eof` exactly two clock cycles later, for every cycle including idle ones, and are zero after reset.
- R2: Bytes are numbered from 0 at the start-of-frame byte. A frame that reaches byte 13 gets exactly one verdict. `verdict_valid` pulses in the cycle where `fw_data` carries byte 13, and this holds even when byte 13 is also the last byte.
- R3: A frame whose end-of-frame byte comes before byte 13 gets one verdict with `verdict_pass` = 0, in the cycle where its end-of-frame byte appears on the output.
- R4: A frame with destination FF-FF-FF-FF-FF-FF passes only if flag bit 3 is set (unless R7 or R8 decides it).
- R5: A frame is multicast when it is not broadcast and the least significant bit of destination byte 0 is 1. Such a frame passes only if flag bit 4 is set and its destination equals the group address. Byte 0 of that address is `grp_addr_hi[15:8]`, byte 1 is `grp_addr_hi[7:0]`, and bytes 2 to 5 are `grp_addr_lo[31:24]`, `[23:16]`, `[15:8]` and `[7:0]`.
- R6: Every other frame passes only if flag bit 5 is set and its destination equals the station address. The station address is in `own_addr_hi`/`own_addr_lo`, with the same byte layout as in R5.
- R7: With flag bit 1 set, every frame that is not pause-class passes, whatever its destination.
- R8: A frame is pause-class when its destination is 01-80-C2-00-00-01 and bytes 12 and 13 hold 0x88 and 0x08. A pause-class frame passes exactly when flag bit 2 is set, whatever the other flags are.
- R9: `pause_seen` pulses for one cycle, in the cycle where `fw_data` carries byte 17, when all of these hold: the frame is pause-class, bytes 14 and 15 are 0x00 and 0x01, flag bit 0 is set, and the frame reaches byte 17. In that cycle `pause_quanta` changes to {byte16, byte17} and then holds. It is reported independently of the verdict. A frame that does not meet all of these conditions produces no pulse.
- R10: A start-of-frame byte restarts parsing even in the middle of a frame, and the abandoned frame gets no verdict. Valid bytes that arrive outside a frame (after an end-of-frame byte and before the next start-of-frame) are ignored by the parser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_flags | input | 6 | Flags: 0 honour pause, 1 promiscuous, 2 forward pause, 3 broadcast, 4 multicast, 5 unicast |
| own_addr_hi | input | 16 | Station address bytes 0 and 1 |
| own_addr_lo | input | 32 | Station address bytes 2 to 5 |
| grp_addr_hi | input | 16 | Group address bytes 0 and 1 |
| grp_addr_lo | input | 32 | Group address bytes 2 to 5 |
| rx_data | input | 8 | Incoming frame byte |
| rx_valid | input | 1 | `rx_data` carries a byte |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| fw_data | output | 8 | Delayed frame byte |
| fw_valid | output | 1 | Delayed valid |
| fw_sof | output | 1 | Delayed start marker |
| fw_eof | output | 1 | Delayed end marker |
| verdict_valid | output | 1 | Verdict strobe, one per frame |
| verdict_pass | output | 1 | 1 = forward, 0 = drop, meaningful with `verdict_valid` |
| pause_seen | output | 1 | Pause request received |
| pause_quanta | output | 16 | Pause time of the last reported request |

## Verification
The header-complete decision and the end-of-frame short-frame drop are two different paths that both create a verdict, and both can fire in the same cycle. This happens when a frame ends exactly on byte 13. It is provoked with frames of 13 and 14 bytes and with frames sent back-to-back with no idle gap. The judgement is that exactly one verdict appears: a drop for 13 bytes, and the address-based result for 14 bytes. A second case joins the verdict of one frame with a restart. A short frame's drop and the next frame's start-of-frame are placed on adjacent cycles, and the next frame's verdict is checked for correct classification.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int IDX_W  = 5;
    localparam int ADDR_W = 48;
    localparam int NFLAGS = 6;

    typedef logic [IDX_W-1:0] idx_t;

    // flag bit positions
    localparam int F_HONOR_PAUSE = 0;
    localparam int F_PROMISC     = 1;
    localparam int F_FWD_PAUSE   = 2;
    localparam int F_BCAST       = 3;
    localparam int F_MCAST       = 4;
    localparam int F_UCAST       = 5;

    // header byte positions (byte 0 carries the start marker)
    localparam idx_t I_DA_LAST = idx_t'(5);
    localparam idx_t I_TYPE_HI = idx_t'(12);
    localparam idx_t I_TYPE_LO = idx_t'(13);
    localparam idx_t I_OP_HI   = idx_t'(14);
    localparam idx_t I_OP_LO   = idx_t'(15);
    localparam idx_t I_PQ_HI   = idx_t'(16);
    localparam idx_t I_PQ_LO   = idx_t'(17);

    localparam logic [ADDR_W-1:0] PAUSE_DA   = 48'h0180_C200_0001;
    localparam logic [ADDR_W-1:0] BCAST_DA   = '1;
    localparam logic [15:0]       ETYPE_CTRL = 16'h8808;
    localparam logic [15:0]       OP_PAUSE   = 16'h0001;

    typedef enum logic [1:0] {
        FC_UCAST,
        FC_MCAST,
        FC_BCAST,
        FC_PAUSE
    } fclass_t;

    typedef struct packed {
        logic [ADDR_W-1:0] da;
        logic [15:0]       etype;
        logic [15:0]       opcode;
        logic [15:0]       quanta;
    } hdr_t;

endpackage

// File: rtl/rxf_delay.sv
module rxf_delay #(
    parameter int W      = 11,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] pipe_d [STAGES];
    logic [W-1:0] pipe_q [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_head
                always_comb pipe_d[g] = din;
            end else begin : g_tail
                always_comb pipe_d[g] = pipe_q[g-1];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q[g] <= '0;
                else        pipe_q[g] <= pipe_d[g];
            end
        end
    endgenerate

    assign dout = pipe_q[STAGES-1];

endmodule

// File: rtl/rxf_hdr_parse.sv
module rxf_hdr_parse
    import rxf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] in_data,
    input  logic       in_valid,
    input  logic       in_sof,
    input  logic       in_eof,
    output hdr_t       hdr_o,
    output logic       hdr_done_o,
    output logic       short_end_o,
    output logic       pq_done_o
);

    typedef struct packed {
        idx_t cnt;
        logic in_frm;
        logic decided;
        hdr_t hdr;
        logic hdr_done;
        logic short_end;
        logic pq_done;
    } pst_t;

    pst_t st_d, st_q;
    logic take;
    idx_t cur;

    always_comb begin
        st_d           = st_q;
        st_d.hdr_done  = 1'b0;
        st_d.short_end = 1'b0;
        st_d.pq_done   = 1'b0;
        take = in_valid && (in_sof || st_q.in_frm);
        cur  = in_sof ? '0 : st_q.cnt;
        if (take) begin
            if (in_sof) st_d.decided = 1'b0;
            if (cur <= I_DA_LAST)
                st_d.hdr.da = {st_q.hdr.da[ADDR_W-9:0], in_data};
            case (cur)
                I_TYPE_HI: st_d.hdr.etype[15:8]  = in_data;
                I_TYPE_LO: st_d.hdr.etype[7:0]   = in_data;
                I_OP_HI:   st_d.hdr.opcode[15:8] = in_data;
                I_OP_LO:   st_d.hdr.opcode[7:0]  = in_data;
                I_PQ_HI:   st_d.hdr.quanta[15:8] = in_data;
                I_PQ_LO:   st_d.hdr.quanta[7:0]  = in_data;
                default: ;
            endcase
            if (cur == I_TYPE_LO && !st_d.decided) begin
                st_d.hdr_done = 1'b1;
                st_d.decided  = 1'b1;
            end else if (in_eof && !st_d.decided) begin
                st_d.short_end = 1'b1;
                st_d.decided   = 1'b1;
            end
            if (cur == I_PQ_LO) st_d.pq_done = 1'b1;
            st_d.cnt    = (cur == '1) ? cur : cur + idx_t'(1);
            st_d.in_frm = !in_eof;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hdr_o       = st_q.hdr;
    assign hdr_done_o  = st_q.hdr_done;
    assign short_end_o = st_q.short_end;
    assign pq_done_o   = st_q.pq_done;

    AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        !(hdr_done_o && short_end_o)) else $error("verdict causes overlap"); // R2

endmodule

// File: rtl/rxf_verdict.sv
module rxf_verdict
    import rxf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NFLAGS-1:0] flags_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic [ADDR_W-1:0] grp_addr_i,
    input  hdr_t              hdr_i,
    input  logic              hdr_done_i,
    input  logic              short_end_i,
    output logic              is_pause_o,
    output logic              verdict_valid_o,
    output logic              verdict_pass_o
);

    typedef struct packed {
        logic vv;
        logic vp;
    } vst_t;

    vst_t    st_d, st_q;
    fclass_t cls;
    logic    pass;

    always_comb begin
        is_pause_o = (hdr_i.da == PAUSE_DA) && (hdr_i.etype == ETYPE_CTRL);
        if (is_pause_o)               cls = FC_PAUSE;
        else if (hdr_i.da == BCAST_DA) cls = FC_BCAST;
        else if (hdr_i.da[ADDR_W-8])   cls = FC_MCAST;
        else                           cls = FC_UCAST;

        case (cls)
            FC_PAUSE: pass = flags_i[F_FWD_PAUSE];
            FC_BCAST: pass = flags_i[F_PROMISC] || flags_i[F_BCAST];
            FC_MCAST: pass = flags_i[F_PROMISC] ||
                             (flags_i[F_MCAST] && hdr_i.da == grp_addr_i);
            default:  pass = flags_i[F_PROMISC] ||
                             (flags_i[F_UCAST] && hdr_i.da == own_addr_i);
        endcase

        st_d.vv = hdr_done_i || short_end_i;
        st_d.vp = hdr_done_i && pass;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign verdict_valid_o = st_q.vv;
    assign verdict_pass_o  = st_q.vp;

    AST_SHORT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        short_end_i |=> (verdict_valid_o && !verdict_pass_o)) else $error("short frame not dropped"); // R3
    AST_PROMISC_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_done_i && flags_i[F_PROMISC] && !is_pause_o) |=> verdict_pass_o) else $error("promiscuous drop"); // R7
    AST_PAUSE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_done_i && is_pause_o && !flags_i[F_FWD_PAUSE]) |=> !verdict_pass_o) else $error("pause forwarded"); // R8

endmodule

// File: rtl/rxf_pause_rep.sv
module rxf_pause_rep
    import rxf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        honor_i,
    input  logic        is_pause_i,
    input  hdr_t        hdr_i,
    input  logic        pq_done_i,
    output logic        pause_seen_o,
    output logic [15:0] pause_quanta_o
);

    typedef struct packed {
        logic        seen;
        logic [15:0] quanta;
    } qst_t;

    qst_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.seen = pq_done_i && honor_i && is_pause_i && (hdr_i.opcode == OP_PAUSE);
        if (st_d.seen) st_d.quanta = hdr_i.quanta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pause_seen_o   = st_q.seen;
    assign pause_quanta_o = st_q.quanta;

    AST_QUANTA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pause_seen_o |-> $stable(pause_quanta_o)) else $error("quanta moved"); // R9

endmodule

// File: rtl/rx_frame_filter.sv
module rx_frame_filter
    import rxf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [5:0]  set_flags,
    input  logic [15:0] own_addr_hi,
    input  logic [31:0] own_addr_lo,
    input  logic [15:0] grp_addr_hi,
    input  logic [31:0] grp_addr_lo,
    input  logic [7:0]  rx_data,
    input  logic        rx_valid,
    input  logic        rx_sof,
    input  logic        rx_eof,
    output logic [7:0]  fw_data,
    output logic        fw_valid,
    output logic        fw_sof,
    output logic        fw_eof,
    output logic        verdict_valid,
    output logic        verdict_pass,
    output logic        pause_seen,
    output logic [15:0] pause_quanta
);

    localparam int SW  = 11;
    localparam int LAT = 2;

    hdr_t hdr;
    logic hdr_done, short_end, pq_done, is_pause;
    logic [SW-1:0] s_in, s_out;

    assign s_in = {rx_valid, rx_sof, rx_eof, rx_data};

    rxf_delay #(.W(SW), .STAGES(LAT)) u_delay (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (s_in),
        .dout (s_out)
    );

    assign {fw_valid, fw_sof, fw_eof, fw_data} = s_out;

    rxf_hdr_parse u_parse (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_data    (rx_data),
        .in_valid   (rx_valid),
        .in_sof     (rx_sof),
        .in_eof     (rx_eof),
        .hdr_o      (hdr),
        .hdr_done_o (hdr_done),
        .short_end_o(short_end),
        .pq_done_o  (pq_done)
    );

    rxf_verdict u_verdict (
        .clk            (clk),
        .rst_n          (rst_n),
        .flags_i        (set_flags),
        .own_addr_i     ({own_addr_hi, own_addr_lo}),
        .grp_addr_i     ({grp_addr_hi, grp_addr_lo}),
        .hdr_i          (hdr),
        .hdr_done_i     (hdr_done),
        .short_end_i    (short_end),
        .is_pause_o     (is_pause),
        .verdict_valid_o(verdict_valid),
        .verdict_pass_o (verdict_pass)
    );

    rxf_pause_rep u_pause (
        .clk           (clk),
        .rst_n         (rst_n),
        .honor_i       (set_flags[F_HONOR_PAUSE]),
        .is_pause_i    (is_pause),
        .hdr_i         (hdr),
        .pq_done_i     (pq_done),
        .pause_seen_o  (pause_seen),
        .pause_quanta_o(pause_quanta)
    );

    AST_STREAM_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ##2 fw_valid) else $error("stream latency"); // R1
    AST_VERDICT_ON_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_valid |-> fw_valid) else $error("verdict off a byte"); // R2
    AST_PAUSE_ON_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        pause_seen |-> (fw_valid && !verdict_valid)) else $error("pause strobe off a byte"); // R9

endmodule

// File: tb/rx_frame_filter_tb.sv
module rx_frame_filter_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  set_flags = '0;
    logic [15:0] own_addr_hi = 16'h0200;
    logic [31:0] own_addr_lo = 32'h00AA_BBCC;
    logic [15:0] grp_addr_hi = 16'h0100;
    logic [31:0] grp_addr_lo = 32'h5E00_0007;
    logic [7:0]  rx_data = '0;
    logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
    logic [7:0]  fw_data;
    logic        fw_valid, fw_sof, fw_eof;
    logic        verdict_valid, verdict_pass, pause_seen;
    logic [15:0] pause_quanta;

    always #4 clk = ~clk;

    rx_frame_filter u_dut (.*);

    int checks = 0, errors = 0;
    bit done = 0;

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int          mi;
    bit          minf, mdec;
    logic [47:0] mda;
    logic [15:0] met, mop;
    logic [7:0]  mpq_hi;
    logic [10:0] s1_str, s2_str;
    bit          s1_vv, s2_vv, s1_vp, s2_vp, s1_ps, s2_ps;
    logic [15:0] s1_pq, s2_pq, exp_quanta;
    string       s1_tag, s2_tag;

    function automatic bit ref_pass(input logic [47:0] da, input logic [15:0] et,
                                    input logic [5:0] c, output string tg);
        if (da == 48'h0180C2000001 && et == 16'h8808) begin tg = "R8"; return c[2]; end
        if (c[1]) begin tg = "R7"; return 1'b1; end
        if (da == 48'hFFFF_FFFF_FFFF) begin tg = "R4"; return c[3]; end
        if (da[40]) begin tg = "R5"; return c[4] && da == {grp_addr_hi, grp_addr_lo}; end
        tg = "R6";
        return c[5] && da == {own_addr_hi, own_addr_lo};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mi = 0; minf = 0; mdec = 0; mda = '0; met = '0; mop = '0; mpq_hi = '0;
            s1_str = '0; s2_str = '0; s1_vv = 0; s2_vv = 0; s1_vp = 0; s2_vp = 0;
            s1_ps = 0; s2_ps = 0; s1_pq = '0; s2_pq = '0; exp_quanta = '0;
            s1_tag = "R1"; s2_tag = "R1";
        end else begin
            bit vv, vp, ps;
            logic [15:0] pq;
            string tg;
            vv = 0; vp = 0; ps = 0; pq = '0; tg = "R2";
            if (rx_valid && (rx_sof || minf)) begin
                int idx;
                idx = rx_sof ? 0 : mi;
                if (rx_sof) mdec = 0;
                if (idx <= 5) mda = {mda[39:0], rx_data};
                if (idx == 12) met[15:8] = rx_data;
                if (idx == 13) met[7:0] = rx_data;
                if (idx == 14) mop[15:8] = rx_data;
                if (idx == 15) mop[7:0] = rx_data;
                if (idx == 16) mpq_hi = rx_data;
                if (idx == 13 && !mdec) begin
                    vv = 1; vp = ref_pass(mda, met, set_flags, tg); mdec = 1;
                end else if (rx_eof && !mdec) begin
                    vv = 1; vp = 0; tg = "R3"; mdec = 1;
                end
                if (idx == 17 && set_flags[0] && mda == 48'h0180C2000001 &&
                    met == 16'h8808 && mop == 16'h0001) begin
                    ps = 1; pq = {mpq_hi, rx_data};
                end
                mi = (idx >= 31) ? 31 : idx + 1;
                minf = !rx_eof;
            end
            s2_str = s1_str; s2_vv = s1_vv; s2_vp = s1_vp; s2_ps = s1_ps; s2_pq = s1_pq; s2_tag = s1_tag;
            s1_str = {rx_valid, rx_sof, rx_eof, rx_data};
            s1_vv = vv; s1_vp = vp; s1_ps = ps; s1_pq = pq; s1_tag = tg;
            if (s2_ps) exp_quanta = s2_pq;
        end
    end

    // per-cycle comparison and event capture
    int vcount = 0, pcount = 0;
    bit vlast = 0;
    logic [15:0] plast = '0;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk({fw_valid, fw_sof, fw_eof, fw_data} == s2_str, "R1", "stream",
                {fw_valid, fw_sof, fw_eof, fw_data}, s2_str);
            chk(verdict_valid == s2_vv, "R2", "verdict_valid", verdict_valid, s2_vv);
            if (s2_vv)
                chk(verdict_pass == s2_vp, s2_tag, "verdict_pass", verdict_pass, s2_vp);
            chk(pause_seen == s2_ps, "R9", "pause_seen", pause_seen, s2_ps);
            chk(pause_quanta == exp_quanta, "R9", "pause_quanta", pause_quanta, exp_quanta);
            if (verdict_valid) begin vcount++; vlast = verdict_pass; end
            if (pause_seen) begin pcount++; plast = pause_quanta; end
        end
    end

    // ---------------- stimulus ----------------
    logic [7:0] fb [64];

    task automatic build(logic [47:0] da, logic [15:0] et, logic [15:0] op, logic [15:0] pq);
        for (int i = 0; i < 64; i++) fb[i] = 8'(i * 7 + 3);
        for (int i = 0; i < 6; i++) fb[i] = da[47 - 8*i -: 8];
        for (int i = 6; i < 12; i++) fb[i] = 8'h10 + 8'(i);
        fb[12] = et[15:8]; fb[13] = et[7:0];
        fb[14] = op[15:8]; fb[15] = op[7:0];
        fb[16] = pq[15:8]; fb[17] = pq[7:0];
    endtask

    task automatic drive(int n, bit with_sof, bit with_eof);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_sof   = with_sof && (i == 0);
            rx_eof   = with_eof && (i == n - 1);
            rx_data  = fb[i];
        end
    endtask

    task automatic idle(int n);
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic run_frame(logic [47:0] da, logic [15:0] et, logic [15:0] op, logic [15:0] pq,
                             int len, bit exp_pass, int exp_strobe, string tag);
        int v0, p0;
        v0 = vcount; p0 = pcount;
        build(da, et, op, pq);
        drive(len, 1, 1);
        idle(4);
        chk(vcount == v0 + 1, tag, "verdict count", vcount - v0, 1);
        chk(vlast == exp_pass, tag, "frame verdict", vlast, exp_pass);
        chk(pcount == p0 + exp_strobe, tag, "pause strobes", pcount - p0, exp_strobe);
        if (exp_strobe > 0) chk(plast == pq, tag, "reported quanta", plast, pq);
    endtask

    localparam logic [47:0] OWN  = 48'h0200_00AA_BBCC;
    localparam logic [47:0] GRP  = 48'h0100_5E00_0007;
    localparam logic [47:0] PDA  = 48'h0180_C200_0001;
    localparam logic [47:0] BC   = 48'hFFFF_FFFF_FFFF;

    initial begin
        repeat (3) @(negedge clk);
        chk({fw_valid, verdict_valid, pause_seen, pause_quanta} == '0, "R1", "reset state",
            {fw_valid, verdict_valid, pause_seen, pause_quanta}, 0);
        rst_n = 1'b1;
        idle(2);

        set_flags = 6'b101000;                                       // ucast + bcast
        run_frame(OWN, 16'h0800, 0, 0, 64, 1, 0, "R6");
        run_frame(48'h0200_00AA_BBCD, 16'h0800, 0, 0, 64, 0, 0, "R6");
        run_frame(BC, 16'h0806, 0, 0, 60, 1, 0, "R4");
        run_frame(GRP, 16'h0800, 0, 0, 60, 0, 0, "R5");
        set_flags = 6'b011000;                                       // mcast + bcast
        run_frame(GRP, 16'h0800, 0, 0, 60, 1, 0, "R5");
        run_frame(48'h0100_5E00_0008, 16'h0800, 0, 0, 60, 0, 0, "R5");
        run_frame(OWN, 16'h0800, 0, 0, 60, 0, 0, "R6");
        set_flags = 6'b000000;
        run_frame(BC, 16'h0806, 0, 0, 60, 0, 0, "R4");
        set_flags = 6'b000010;                                       // promiscuous
        run_frame(48'h0200_1111_2222, 16'h0800, 0, 0, 60, 1, 0, "R7");
        run_frame(48'h0300_0000_0009, 16'h0800, 0, 0, 60, 1, 0, "R7");
        run_frame(PDA, 16'h8808, 16'h0001, 16'h1234, 60, 0, 0, "R8");
        set_flags = 6'b111001;                                       // honour, no forward
        run_frame(PDA, 16'h8808, 16'h0001, 16'h1234, 60, 0, 1, "R9");
        set_flags = 6'b000101;
        run_frame(PDA, 16'h8808, 16'h0001, 16'hBEEF, 60, 1, 1, "R8");
        run_frame(PDA, 16'h8808, 16'h0002, 16'h5555, 60, 1, 0, "R9");
        run_frame(PDA, 16'h8808, 16'h0001, 16'h7777, 17, 1, 0, "R9");
        run_frame(PDA, 16'h8808, 16'h0001, 16'h00A5, 18, 1, 1, "R9");
        set_flags = 6'b000100;
        run_frame(PDA, 16'h8808, 16'h0001, 16'h4444, 60, 1, 0, "R9");
        run_frame(PDA, 16'h0800, 16'h0001, 16'h4444, 60, 0, 0, "R8");

        set_flags = 6'b100000;
        run_frame(OWN, 16'h0800, 0, 0, 10, 0, 0, "R3");
        run_frame(OWN, 16'h0800, 0, 0, 13, 0, 0, "R3");
        run_frame(OWN, 16'h0800, 0, 0, 14, 1, 0, "R2");

        begin : b2b                                                  // R3 then R10 restart
            int v0;
            v0 = vcount;
            build(OWN, 16'h0800, 0, 0);
            drive(5, 1, 1);
            drive(14, 1, 1);
            drive(13, 1, 1);
            idle(4);
            chk(vcount == v0 + 3, "R10", "back-to-back verdicts", vcount - v0, 3);
            chk(vlast == 1'b0, "R3", "last of back-to-back", vlast, 0);
        end

        begin : midsof                                               // R10 abandoned frame
            int v0;
            v0 = vcount;
            build(48'h0200_0000_0001, 16'h0800, 0, 0);
            drive(8, 1, 0);
            build(OWN, 16'h0800, 0, 0);
            drive(20, 1, 1);
            idle(4);
            chk(vcount == v0 + 1, "R10", "restart verdicts", vcount - v0, 1);
            chk(vlast == 1'b1, "R10", "restart verdict", vlast, 1);
        end

        begin : stray                                                // R10 bytes outside frame
            int v0;
            v0 = vcount;
            build(48'hFFFF_FFFF_FFFF, 16'h0800, 0, 0);
            drive(20, 0, 0);
            idle(4);
            chk(vcount == v0, "R10", "stray bytes verdicts", vcount - v0, 0);
            run_frame(OWN, 16'h0800, 0, 0, 30, 1, 0, "R10");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL R1 watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule